// File: doc/BRIEF.md
# Big-endian sub-word load/store lane aligner

This block sits between a core's register file and a 32-bit memory bus that serves RAM and ROM. It is steered directly by the six-bit load/store opcode and turns it into an access size, a direction and a signedness. For a store, it copies the register operand onto the big-endian byte lanes that the low address bits select and raises the matching byte enables. For a load, it takes the word the memory returns, picks out the addressed half-word or byte, and widens it to 32 bits with sign or zero extension.

The block checks no faults and has no handshake. Alignment checks, privilege checks, translation and bus timing all belong to logic around it. Lane order is big-endian: byte offset 0 is data bits 31..24, offset 3 is bits 7..0, and half-word offset 0 is bits 31..16. The parameter `REGISTERED` selects the form of the block. With the value 1, the default, every output is registered once and all inputs, the read data included, are sampled on the same clock edge. With the value 0, the block is pure combinational logic from inputs to outputs.

Top module: `be_lane_aligner`

## Requirements
- R1: `ok_o` is 1 exactly when `op_i[5:3]` is 3'b110 (opcodes 110000 through 110111), and 0 for every other opcode.
- R2: For an opcode outside 110000..110111, `ok_o` is 0 and `wdata_o`, `ben_o` and `ldata_o` are all zero.
- R3: A word store (110101) drives `wdata_o` = `reg_i` and `ben_o` = 4'b1111, whatever the value of `addr_i`.
- R4: A half-word store (110110) drives `wdata_o` = {reg_i[15:0], reg_i[15:0]}. `ben_o` is 4'b1100 when `addr_i[1]`=0 and 4'b0011 when `addr_i[1]`=1. `addr_i[0]` has no effect.
- R5: A byte store (110111) drives `wdata_o` = reg_i[7:0] copied to all four lanes. `ben_o` has only bit 3-`addr_i` set, where `ben_o[3]` is the lane of bits 31..24.
- R6: A load drives `ben_o` = 0 and `wdata_o` = 0. A store drives `ldata_o` = 0.
- R7: A word load (110000) returns `ldata_o` = `rdata_i`, whatever the value of `addr_i`.
- R8: A half-word load takes `rdata_i[31:16]` when `addr_i[1]`=0 and `rdata_i[15:0]` when `addr_i[1]`=1. Opcode 110001 sign-extends the value and opcode 110010 zero-extends it.
- R9: A byte load at offset k takes `rdata_i[31-8k -: 8]`. Opcode 110011 sign-extends the byte and opcode 110100 zero-extends it.
- R10: With `REGISTERED`=1, the outputs show the result for the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are zero. With `REGISTERED`=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only when `REGISTERED`=1 |
| rst_n | input | 1 | Active-low asynchronous reset of the output registers |
| op_i | input | 6 | Load/store opcode |
| addr_i | input | 2 | Byte offset within the word (low physical address bits) |
| reg_i | input | 32 | Register value to store |
| rdata_i | input | 32 | Word returned by memory |
| wdata_o | output | 32 | Store data placed on the byte lanes |
| ben_o | output | 4 | Store byte enables, bit 3 = bits 31..24 |
| ldata_o | output | 32 | Extended load result |
| ok_o | output | 1 | Opcode is a load/store |

## Verification
Store lane placement and load extraction can fall in the same cycle. Each vector drives a store operand and a read word with a sign bit set together, so a store that also leaked a load result would show a non-zero `ldata_o`, and a load would show stray enables or data. Every vector checks all four outputs, on a combinational instance in the same cycle and on a registered instance one edge later. Two cases are judged directly at the ports: an asserted reset that overrides a valid store, and a sweep of all 64 opcodes against the validity rule.

// File: rtl/be_lane_aligner.sv
module be_lane_aligner #(
  parameter bit REGISTERED = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  op_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] reg_i,
  input  logic [31:0] rdata_i,
  output logic [31:0] wdata_o,
  output logic [3:0]  ben_o,
  output logic [31:0] ldata_o,
  output logic        ok_o
);
  localparam logic [2:0] LS_GROUP = 3'b110;

  logic [2:0]  sub;
  logic        op_ok, is_st, sz_w, sz_h, sz_b, sx;
  logic [15:0] half;
  logic [7:0]  byt;
  logic [31:0] wd_c, ld_c;
  logic [3:0]  be_c;

  assign sub   = op_i[2:0];
  assign op_ok = (op_i[5:3] == LS_GROUP);
  assign is_st = op_ok && (sub >= 3'd5);
  assign sz_w  = (sub == 3'd0) || (sub == 3'd5);
  assign sz_h  = (sub == 3'd1) || (sub == 3'd2) || (sub == 3'd6);
  assign sz_b  = (sub == 3'd3) || (sub == 3'd4) || (sub == 3'd7);
  assign sx    = (sub == 3'd1) || (sub == 3'd3);

  assign half = addr_i[1] ? rdata_i[15:0] : rdata_i[31:16];

  always_comb begin
    case (addr_i)
      2'd0:    byt = rdata_i[31:24];
      2'd1:    byt = rdata_i[23:16];
      2'd2:    byt = rdata_i[15:8];
      default: byt = rdata_i[7:0];
    endcase
  end

  always_comb begin
    wd_c = '0;
    be_c = '0;
    ld_c = '0;
    if (is_st) begin
      if (sz_w) begin
        wd_c = reg_i;
        be_c = 4'b1111;
      end else if (sz_h) begin
        wd_c = {2{reg_i[15:0]}};
        be_c = addr_i[1] ? 4'b0011 : 4'b1100;
      end else begin
        wd_c = {4{reg_i[7:0]}};
        be_c = 4'b1000 >> addr_i;
      end
    end else if (op_ok) begin
      if (sz_w)      ld_c = rdata_i;
      else if (sz_h) ld_c = {{16{sx & half[15]}}, half};
      else if (sz_b) ld_c = {{24{sx & byt[7]}}, byt};
    end
  end

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wdata_o <= '0;
          ben_o   <= '0;
          ldata_o <= '0;
          ok_o    <= 1'b0;
        end else begin
          wdata_o <= wd_c;
          ben_o   <= be_c;
          ldata_o <= ld_c;
          ok_o    <= op_ok;
        end
      end
    end else begin : g_comb
      assign wdata_o = wd_c;
      assign ben_o   = be_c;
      assign ldata_o = ld_c;
      assign ok_o    = op_ok;
    end
  endgenerate
endmodule

// File: rtl/be_lane_aligner_chk.sv
module be_lane_aligner_chk #(
  parameter bit REGISTERED = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  op_i,
  input logic [1:0]  addr_i,
  input logic [31:0] wdata_o,
  input logic [3:0]  ben_o,
  input logic [31:0] ldata_o,
  input logic        ok_o
);
  logic [5:0] c_op;
  logic [1:0] c_ad;

  generate
    if (REGISTERED) begin : g_q
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          c_op <= '0;
          c_ad <= '0;
        end else begin
          c_op <= op_i;
          c_ad <= addr_i;
        end
      end
    end else begin : g_d
      assign c_op = op_i;
      assign c_ad = addr_i;
    end
  endgenerate

  // R2
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op[5:3] != 3'b110) |-> (!ok_o && ben_o == 4'd0 && wdata_o == 32'd0 && ldata_o == 32'd0));
  // R3
  word_store_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op == 6'b110101) |-> (ben_o == 4'b1111));
  // R4
  half_store_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op == 6'b110110) |-> (ben_o == (c_ad[1] ? 4'b0011 : 4'b1100)));
  // R5
  byte_store_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op == 6'b110111) |-> ($countones(ben_o) == 1 && ben_o[3 - c_ad]));
  // R6
  load_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op[5:3] == 3'b110 && c_op[2:0] <= 3'd4) |-> (ben_o == 4'd0 && wdata_o == 32'd0));
  // R9
  ubyte_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op == 6'b110100) |-> (ldata_o[31:8] == 24'd0));
endmodule

bind be_lane_aligner be_lane_aligner_chk #(.REGISTERED(REGISTERED)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i),
  .wdata_o(wdata_o), .ben_o(ben_o), .ldata_o(ldata_o), .ok_o(ok_o)
);

// File: tb/be_lane_aligner_tb.sv
`timescale 1ns/1ps
module be_lane_aligner_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0]  op = 6'b110101;
  logic [1:0]  ad = 2'd0;
  logic [31:0] rv = 32'hDEAD_BEEF;
  logic [31:0] rd = 32'h0;
  logic [31:0] wd_r, ld_r, wd_c, ld_c;
  logic [3:0]  be_r, be_c;
  logic        ok_r, ok_c;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  be_lane_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .addr_i(ad), .reg_i(rv), .rdata_i(rd),
    .wdata_o(wd_r), .ben_o(be_r), .ldata_o(ld_r), .ok_o(ok_r));

  be_lane_aligner #(.REGISTERED(1'b0)) u_comb (
    .clk(clk), .rst_n(rst_n), .op_i(op), .addr_i(ad), .reg_i(rv), .rdata_i(rd),
    .wdata_o(wd_c), .ben_o(be_c), .ldata_o(ld_c), .ok_o(ok_c));

  typedef struct packed {
    logic [5:0]  op;
    logic [1:0]  ad;
    logic [31:0] wd;
    logic [3:0]  be;
    logic [31:0] ld;
    logic        ok;
  } vec_t;

  localparam logic [31:0] RV = 32'h1234_56F8;
  localparam logic [31:0] RD = 32'h8A7B_C5D6;
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{6'b110000, 2'd2, 32'h0,         4'h0, 32'h8A7BC5D6, 1'b1},
    '{6'b110001, 2'd0, 32'h0,         4'h0, 32'hFFFF8A7B, 1'b1},
    '{6'b110001, 2'd2, 32'h0,         4'h0, 32'hFFFFC5D6, 1'b1},
    '{6'b110010, 2'd0, 32'h0,         4'h0, 32'h00008A7B, 1'b1},
    '{6'b110010, 2'd3, 32'h0,         4'h0, 32'h0000C5D6, 1'b1},
    '{6'b110011, 2'd1, 32'h0,         4'h0, 32'h0000007B, 1'b1},
    '{6'b110011, 2'd2, 32'h0,         4'h0, 32'hFFFFFFC5, 1'b1},
    '{6'b110100, 2'd0, 32'h0,         4'h0, 32'h0000008A, 1'b1},
    '{6'b110100, 2'd3, 32'h0,         4'h0, 32'h000000D6, 1'b1},
    '{6'b110101, 2'd1, 32'h123456F8,  4'hF, 32'h0,        1'b1},
    '{6'b110110, 2'd0, 32'h56F856F8,  4'hC, 32'h0,        1'b1},
    '{6'b110110, 2'd3, 32'h56F856F8,  4'h3, 32'h0,        1'b1},
    '{6'b110111, 2'd0, 32'hF8F8F8F8,  4'h8, 32'h0,        1'b1},
    '{6'b110111, 2'd1, 32'hF8F8F8F8,  4'h4, 32'h0,        1'b1},
    '{6'b110111, 2'd3, 32'hF8F8F8F8,  4'h1, 32'h0,        1'b1},
    '{6'b000000, 2'd0, 32'h0,         4'h0, 32'h0,        1'b0},
    '{6'b111000, 2'd1, 32'h0,         4'h0, 32'h0,        1'b0},
    '{6'b101111, 2'd2, 32'h0,         4'h0, 32'h0,        1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag(input logic [5:0] o);
    if (o[5:3] != 3'b110) return "R2";
    case (o[2:0])
      3'd0: return "R7";
      3'd1, 3'd2: return "R8";
      3'd3, 3'd4: return "R9";
      3'd5: return "R3";
      3'd6: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10: outputs held at zero under reset even with a valid store applied
    repeat (3) @(negedge clk);
    check("R10 reset wdata", wd_r, 32'h0);
    check("R10 reset ben", {28'h0, be_r}, 32'h0);
    check("R10 reset ok", {31'h0, ok_r}, 32'h0);
    rst_n = 1'b1;

    rv = RV;
    rd = RD;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op = VECS[i].op;
      ad = VECS[i].ad;
      #1;
      // R10: combinational variant, same cycle
      check({tag(VECS[i].op), " comb wdata"}, wd_c, VECS[i].wd);
      check({tag(VECS[i].op), " comb ben"}, {28'h0, be_c}, {28'h0, VECS[i].be});
      check({"R6 ", tag(VECS[i].op), " comb ldata"}, ld_c, VECS[i].ld);
      check("R1 comb ok", {31'h0, ok_c}, {31'h0, VECS[i].ok});
      @(negedge clk);
      // R10: registered variant, one edge later
      check({tag(VECS[i].op), " reg wdata"}, wd_r, VECS[i].wd);
      check({tag(VECS[i].op), " reg ben"}, {28'h0, be_r}, {28'h0, VECS[i].be});
      check({"R6 ", tag(VECS[i].op), " reg ldata"}, ld_r, VECS[i].ld);
      check("R1 reg ok", {31'h0, ok_r}, {31'h0, VECS[i].ok});
    end

    // R1: sweep every opcode
    for (int o = 0; o < 64; o++) begin
      @(negedge clk);
      op = 6'(o);
      #1;
      check("R1 sweep ok", {31'h0, ok_c}, {31'h0, (o >= 48 && o <= 55)});
    end

    // R7: word load ignores the offset
    @(negedge clk);
    op = 6'b110000;
    ad = 2'd3;
    rd = 32'h0102_0304;
    #1;
    check("R7 word load offset 3", ld_c, 32'h0102_0304);

    // R9: positive byte at the last offset under a signed load
    op = 6'b110011;
    rd = 32'hFFFF_FF7E;
    #1;
    check("R9 signed byte positive", ld_c, 32'h0000_007E);

    // R3: word store ignores the offset
    op = 6'b110101;
    ad = 2'd2;
    rv = 32'hCAFE_0001;
    #1;
    check("R3 word store offset 2 ben", {28'h0, be_c}, 32'hF);
    check("R3 word store data", wd_c, 32'hCAFE_0001);

    // R10: reset asserted mid-run clears registered outputs
    @(negedge clk);
    @(negedge clk);
    check("R10 pre-reset ben", {28'h0, be_r}, 32'hF);
    rst_n = 1'b0;
    #1;
    check("R10 async reset ben", {28'h0, be_r}, 32'h0);
    check("R10 async reset wdata", wd_r, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule